// File: doc/BRIEF.md
# SRAM Read Sequencer for a Cascaded Search-Engine Table

This block is the device-side controller used by each chip in a cascade of search-engine devices that share one command bus, one wide data bus and one external SRAM. When the host issues a two-phase Read command aimed at the SRAM address space, every device decodes it. Only the device whose strap ID matches the ID field carried on the data bus takes part on the shared wires.

That device assembles a 22-bit SRAM address from both command phases and holds it in a register. It then runs a fixed eight-cycle schedule. The schedule waits out the host's bus turnaround, drives the data bus, and brings the acknowledge out of high impedance, first low and then high. In one cycle it presents the address and the SRAM strobes. It then releases everything.

Each tri-state wire is modelled as a value plus an output-enable. A device that is not selected follows the same schedule internally, but keeps every enable low. Cycle numbering: phase A is cycle 1A, phase B is cycle 1B, and cycle N (N ≥ 2) is the (N−1)-th clock cycle after phase B.

Top module: `sram_rd_seq`

## Requirements
- R1: A sequence starts only from a phase A with `cmd_vld_i`=1 and `cmd_i[1:0]`=2'b01 (Read); any other opcode, or `cmd_vld_i`=0, has no effect at the outputs.
- R2: Phase A must carry `dq_i[20:19]`=2'b10 (SRAM space); any other value starts nothing.
- R3: A device enables its shared outputs only if `dq_i[25:21]` in phase A equals `dev_id_i`.
- R4: The SRAM address is `{cmd_i[8:7] of phase A, dq_i[35:26] of phase A, dq_i[35:26] of phase B}`. It stays stable while driven, whatever the data bus does after phase B.
- R5: Phase B, the next cycle, must again show `cmd_vld_i`=1, opcode 2'b01 and `dq_i[20:19]`=2'b10. Otherwise the command is dropped and nothing is driven.
- R6: `dq_oe_o` is low in cycles 2 and 3 and high in cycles 4, 5 and 6. The driven value is all zeros.
- R7: In cycle 5, `ack_oe_o` rises with `ack_o`=0.
- R8: In cycle 6 only, `sadr_oe_o` and `ctl_oe_o` are high, with `ce_n_o`=0, `ale_n_o`=0, `we_n_o`=1 and `ack_o`=1.
- R9: In cycle 7, only `ack_oe_o` is high, with `ack_o`=0. From cycle 8 every enable is low, and a phase A presented in cycle 8 is accepted.
- R10: Commands arriving during a sequence are ignored, including the shadow sequence of a non-selected device. A non-selected device drives nothing.
- R11: Synchronous active-high `rst` drops every output-enable at the next edge and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 9 | Command bus: opcode [1:0], upper address [8:7] |
| cmd_vld_i | input | 1 | Command valid strobe |
| dq_i | input | 68 | Shared data bus as seen by the device |
| dev_id_i | input | 5 | Device ID strap |
| dq_o | output | 68 | Value driven on the data bus |
| dq_oe_o | output | 1 | Data bus enable |
| sadr_o | output | 22 | SRAM address |
| sadr_oe_o | output | 1 | SRAM address enable |
| ce_n_o | output | 1 | SRAM chip enable, active low |
| we_n_o | output | 1 | SRAM write enable, active low |
| ale_n_o | output | 1 | Address latch enable, active low |
| ctl_oe_o | output | 1 | Enable for the three SRAM strobes |
| ack_o | output | 1 | Acknowledge value |
| ack_oe_o | output | 1 | Acknowledge enable |

## Verification
A sequencer state that slips by one cycle shows at once as an enable in the wrong cycle. Every cycle is compared against a per-cycle expected pattern, so such a slip shows within the sequence that caused it. A lost or wrong selection flag shows as enables on a device whose ID does not match, or as a missing sequence. A busy state that does not hold shows as a second sequence when a command arrives mid-schedule. A corrupted address register shows in cycle 6 as a wrong `sadr_o`.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PB, ST_C2, ST_C3, ST_C4, ST_C5, ST_C6, ST_C7
  } seq_st_t;

  localparam logic [1:0] OP_READ    = 2'b01;
  localparam logic [1:0] SPACE_SRAM = 2'b10;
endpackage

// File: rtl/srd_cmd_decode.sv
module srd_cmd_decode
  import srd_pkg::*;
#(
  parameter int DQ_W   = 68,
  parameter int CMD_W  = 9,
  parameter int ID_W   = 5,
  parameter int ID_LSB = 21,
  parameter int SP_LSB = 19,
  parameter int AF_LSB = 26,
  parameter int AF_W   = 10,
  parameter int HI_LSB = 7,
  parameter int HI_W   = 2
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_vld_i,
  input  logic [DQ_W-1:0]  dq_i,
  input  logic [ID_W-1:0]  dev_id_i,
  output logic             phase_ok_o,
  output logic             id_hit_o,
  output logic [AF_W-1:0]  fld_o,
  output logic [HI_W-1:0]  hi_o
);
  // bus bits outside the decoded fields are intentionally ignored
  logic unused_bits;
  assign unused_bits = ^{cmd_i, dq_i};

  assign phase_ok_o = cmd_vld_i && (cmd_i[1:0] == OP_READ)
                      && (dq_i[SP_LSB +: 2] == SPACE_SRAM);
  assign id_hit_o   = (dq_i[ID_LSB +: ID_W] == dev_id_i);
  assign fld_o      = dq_i[AF_LSB +: AF_W];
  assign hi_o       = cmd_i[HI_LSB +: HI_W];
endmodule

// File: rtl/srd_addr_latch.sv
module srd_addr_latch #(
  parameter int AF_W = 10,
  parameter int HI_W = 2,
  localparam int SADR_W = HI_W + 2 * AF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [AF_W-1:0]   fld_i,
  output logic [SADR_W-1:0] sadr_o
);
  logic [HI_W-1:0] hi_q;
  logic [AF_W-1:0] mid_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      mid_q <= '0;
      lo_q  <= '0;
    end else begin
      if (cap_a_i) begin
        hi_q  <= hi_i;
        mid_q <= fld_i;
      end
      if (cap_b_i) lo_q <= fld_i;
    end
  end

  assign sadr_o = {hi_q, mid_q, lo_q};
endmodule

// File: rtl/srd_seq_ctrl.sv
module srd_seq_ctrl
  import srd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic phase_ok_i,
  input  logic id_hit_i,
  output logic cap_a_o,
  output logic cap_b_o,
  output logic dq_oe_o,
  output logic sadr_oe_o,
  output logic ctl_oe_o,
  output logic ce_n_o,
  output logic we_n_o,
  output logic ale_n_o,
  output logic ack_o,
  output logic ack_oe_o
);
  seq_st_t st_q, st_n;
  logic    sel_q, sel_n;

  assign cap_a_o = (st_q == ST_IDLE) && phase_ok_i;
  assign cap_b_o = (st_q == ST_PB) && phase_ok_i;
  assign sel_n   = cap_a_o ? id_hit_i : sel_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: if (phase_ok_i) st_n = ST_PB;
      ST_PB:   st_n = phase_ok_i ? ST_C2 : ST_IDLE;
      ST_C2:   st_n = ST_C3;
      ST_C3:   st_n = ST_C4;
      ST_C4:   st_n = ST_C5;
      ST_C5:   st_n = ST_C6;
      ST_C6:   st_n = ST_C7;
      ST_C7:   st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      sel_q <= sel_n;
    end
  end

  // outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe_o   <= 1'b0;
      sadr_oe_o <= 1'b0;
      ctl_oe_o  <= 1'b0;
      ce_n_o    <= 1'b1;
      we_n_o    <= 1'b1;
      ale_n_o   <= 1'b1;
      ack_o     <= 1'b0;
      ack_oe_o  <= 1'b0;
    end else begin
      dq_oe_o   <= sel_n && (st_n == ST_C4 || st_n == ST_C5 || st_n == ST_C6);
      sadr_oe_o <= sel_n && (st_n == ST_C6);
      ctl_oe_o  <= sel_n && (st_n == ST_C6);
      ce_n_o    <= !(sel_n && (st_n == ST_C6));
      ale_n_o   <= !(sel_n && (st_n == ST_C6));
      we_n_o    <= 1'b1;
      ack_o     <= sel_n && (st_n == ST_C6);
      ack_oe_o  <= sel_n && (st_n == ST_C5 || st_n == ST_C6 || st_n == ST_C7);
    end
  end

  assert_dq_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe_o) |-> (!ack_oe_o && !sadr_oe_o && !ctl_oe_o));

  assert_ack_enters_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_oe_o) |-> (!ack_o && dq_oe_o));

  assert_strobe_group_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_oe_o |-> (sadr_oe_o && ack_o && ack_oe_o && !ce_n_o && !ale_n_o && we_n_o && dq_oe_o));

  assert_ack_tail_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_oe_o) |-> (ack_oe_o && !ack_o && !dq_oe_o && !sadr_oe_o));

  assert_ack_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_oe_o) |-> ($past(!ack_o) && !dq_oe_o && !ctl_oe_o));
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
  import srd_pkg::*;
#(
  parameter int DQ_W   = 68,
  parameter int CMD_W  = 9,
  parameter int ID_W   = 5,
  parameter int AF_LSB = 26,
  parameter int AF_W   = 10,
  localparam int HI_W   = 2,
  localparam int SADR_W = HI_W + 2 * AF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cmd_vld_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [SADR_W-1:0] sadr_o,
  output logic              sadr_oe_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              ale_n_o,
  output logic              ctl_oe_o,
  output logic              ack_o,
  output logic              ack_oe_o
);
  localparam int ID_LSB = 21;
  localparam int SP_LSB = 19;
  localparam int HI_LSB = 7;

  logic            phase_ok, id_hit, cap_a, cap_b;
  logic [AF_W-1:0] fld;
  logic [HI_W-1:0] hi;

  srd_cmd_decode #(
    .DQ_W(DQ_W), .CMD_W(CMD_W), .ID_W(ID_W), .ID_LSB(ID_LSB), .SP_LSB(SP_LSB),
    .AF_LSB(AF_LSB), .AF_W(AF_W), .HI_LSB(HI_LSB), .HI_W(HI_W)
  ) u_dec (
    .cmd_i(cmd_i), .cmd_vld_i(cmd_vld_i), .dq_i(dq_i), .dev_id_i(dev_id_i),
    .phase_ok_o(phase_ok), .id_hit_o(id_hit), .fld_o(fld), .hi_o(hi)
  );

  srd_addr_latch #(.AF_W(AF_W), .HI_W(HI_W)) u_addr (
    .clk(clk), .rst(rst), .cap_a_i(cap_a), .cap_b_i(cap_b),
    .hi_i(hi), .fld_i(fld), .sadr_o(sadr_o)
  );

  srd_seq_ctrl u_seq (
    .clk(clk), .rst(rst), .phase_ok_i(phase_ok), .id_hit_i(id_hit),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .dq_oe_o(dq_oe_o), .sadr_oe_o(sadr_oe_o),
    .ctl_oe_o(ctl_oe_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o), .ale_n_o(ale_n_o),
    .ack_o(ack_o), .ack_oe_o(ack_oe_o)
  );

  assign dq_o = '0;

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    sadr_oe_o |-> $stable(sadr_o));
endmodule

// File: tb/tb_sram_rd_seq.sv
module tb_sram_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MY_ID = 5'd13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  cmd_i = '0;
  logic        cmd_vld_i = 1'b0;
  logic [67:0] dq_i = '0;
  logic [67:0] dq_o;
  logic        dq_oe_o, sadr_oe_o, ce_n_o, we_n_o, ale_n_o, ctl_oe_o, ack_o, ack_oe_o;
  logic [21:0] sadr_o;

  sram_rd_seq dut (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .cmd_vld_i(cmd_vld_i), .dq_i(dq_i),
    .dev_id_i(MY_ID), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .sadr_o(sadr_o),
    .sadr_oe_o(sadr_oe_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o), .ale_n_o(ale_n_o),
    .ctl_oe_o(ctl_oe_o), .ack_o(ack_o), .ack_oe_o(ack_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          cyc;
    bit          dq_oe, sadr_oe, ctl_oe, ack_oe, ack;
    logic [21:0] sadr;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    running = 1'b0, done = 1'b0;
  string idle_tag = "R11";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [67:0] act, logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [67:0] junk();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[67:0];
  endfunction

  // monitor: compare every cycle against the scoreboard head or the idle pattern
  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      e.cyc = cyc; e.dq_oe = 0; e.sadr_oe = 0; e.ctl_oe = 0; e.ack_oe = 0; e.ack = 0;
      e.sadr = '0; e.tag = idle_tag;
      while (q.size() > 0 && q[0].cyc < cyc) void'(q.pop_front());
      if (q.size() > 0 && q[0].cyc == cyc) e = q.pop_front();
      chk(e.tag, "dq_oe",   68'(dq_oe_o),   68'(e.dq_oe));
      chk(e.tag, "sadr_oe", 68'(sadr_oe_o), 68'(e.sadr_oe));
      chk(e.tag, "ctl_oe",  68'(ctl_oe_o),  68'(e.ctl_oe));
      chk(e.tag, "ack_oe",  68'(ack_oe_o),  68'(e.ack_oe));
      if (e.ack_oe)  chk(e.tag, "ack", 68'(ack_o), 68'(e.ack));
      if (e.sadr_oe) chk(e.tag, "sadr", 68'(sadr_o), 68'(e.sadr));
      if (e.dq_oe)   chk(e.tag, "dq_value", dq_o, 68'd0);
      if (e.ctl_oe) begin
        chk(e.tag, "ce_n", 68'(ce_n_o), 68'd0);
        chk(e.tag, "ale_n", 68'(ale_n_o), 68'd0);
        chk(e.tag, "we_n", 68'(we_n_o), 68'd1);
      end
    end
  end

  // driver: called at a negedge, drives phase A then B, pushes expectations
  task automatic send_read(input logic [1:0] op_a, input logic [1:0] sp_a, input logic [4:0] id_a,
                           input logic [1:0] hi, input logic [9:0] mid,
                           input logic vld_b, input logic [1:0] sp_b, input logic [9:0] lo,
                           input bit busy, input int cut);
    int   k;
    bit   run;
    logic [67:0] d;
    logic [21:0] a;
    exp_t e;
    k   = cyc;
    run = !busy && (op_a == 2'b01) && (sp_a == 2'b10) && (id_a == MY_ID)
          && vld_b && (sp_b == 2'b10);
    a   = {hi, mid, lo};
    if (run) begin
      for (int n = 4; n <= 7; n++) begin
        if (n < cut) begin
          e.cyc = k + n; e.sadr = a; e.tag = (n == 4) ? "R6" : (n == 5) ? "R7" : (n == 6) ? "R8" : "R9";
          e.dq_oe = (n <= 6); e.sadr_oe = (n == 6); e.ctl_oe = (n == 6);
          e.ack_oe = (n >= 5); e.ack = (n == 6);
          q.push_back(e);
        end
      end
    end
    d = junk(); d[20:19] = sp_a; d[25:21] = id_a; d[35:26] = mid;
    dq_i = d; cmd_i = {hi, 5'($urandom()), op_a}; cmd_vld_i = 1'b1;
    @(negedge clk);
    d = junk(); d[20:19] = sp_b; d[25:21] = ~MY_ID; d[35:26] = lo;
    dq_i = d; cmd_i = {2'($urandom()), 5'($urandom()), 2'b01}; cmd_vld_i = vld_b;
    @(negedge clk);
    dq_i = junk(); cmd_i = 9'($urandom()); cmd_vld_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset dq_oe", 68'(dq_oe_o), 68'd0);
    chk("R11", "reset ack_oe", 68'(ack_oe_o), 68'd0);
    chk("R11", "reset sadr_oe", 68'(sadr_oe_o), 68'd0);
    chk("R11", "reset ctl_oe", 68'(ctl_oe_o), 68'd0);
    rst = 1'b0;
    running = 1'b1;
    idle(2);

    // R1 R3 R4 R6 R7 R8 R9: basic selected read
    idle_tag = "R9";
    send_read(2'b01, 2'b10, MY_ID, 2'b10, 10'h2A5, 1'b1, 2'b10, 10'h15A, 0, 8);
    idle(8);

    // R4: data bus churns after phase B, address must hold
    idle_tag = "R4";
    send_read(2'b01, 2'b10, MY_ID, 2'b11, 10'h3FF, 1'b1, 2'b10, 10'h000, 0, 8);
    for (int i = 0; i < 8; i++) begin
      dq_i = junk(); cmd_i = 9'($urandom());
      @(negedge clk);
    end

    // R2: wrong address space in phase A
    idle_tag = "R2";
    send_read(2'b01, 2'b01, MY_ID, 2'b01, 10'h111, 1'b1, 2'b10, 10'h222, 0, 8);
    idle(8);
    send_read(2'b01, 2'b11, MY_ID, 2'b01, 10'h111, 1'b1, 2'b10, 10'h222, 0, 8);
    idle(8);

    // R1: other opcodes
    idle_tag = "R1";
    send_read(2'b10, 2'b10, MY_ID, 2'b01, 10'h0F0, 1'b1, 2'b10, 10'h00F, 0, 8);
    idle(8);
    send_read(2'b00, 2'b10, MY_ID, 2'b01, 10'h0F0, 1'b1, 2'b10, 10'h00F, 0, 8);
    idle(8);

    // R5: phase B invalid
    idle_tag = "R5";
    send_read(2'b01, 2'b10, MY_ID, 2'b01, 10'h0AA, 1'b0, 2'b10, 10'h055, 0, 8);
    idle(8);
    send_read(2'b01, 2'b10, MY_ID, 2'b01, 10'h0AA, 1'b1, 2'b00, 10'h055, 0, 8);
    idle(8);

    // R3 R10: other device selected, then a matching command during the shadow
    idle_tag = "R10";
    send_read(2'b01, 2'b10, MY_ID ^ 5'd1, 2'b01, 10'h123, 1'b1, 2'b10, 10'h321, 0, 8);
    send_read(2'b01, 2'b10, MY_ID, 2'b10, 10'h1C3, 1'b1, 2'b10, 10'h0E1, 1, 8);
    idle(8);

    // R10: command during own sequence is ignored
    send_read(2'b01, 2'b10, MY_ID, 2'b00, 10'h3C3, 1'b1, 2'b10, 10'h0C3, 0, 8);
    send_read(2'b01, 2'b10, MY_ID, 2'b11, 10'h001, 1'b1, 2'b10, 10'h002, 1, 8);
    idle(8);

    // R9: next command presented in cycle 8 is accepted
    idle_tag = "R9";
    send_read(2'b01, 2'b10, MY_ID, 2'b01, 10'h155, 1'b1, 2'b10, 10'h2AA, 0, 8);
    idle(6);
    send_read(2'b01, 2'b10, MY_ID, 2'b10, 10'h0FF, 1'b1, 2'b10, 10'h300, 0, 8);
    idle(8);

    // R11: reset in cycle 4 drops everything at the next edge
    idle_tag = "R11";
    send_read(2'b01, 2'b10, MY_ID, 2'b11, 10'h246, 1'b1, 2'b10, 10'h135, 0, 5);
    idle(2);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    idle(8);
    send_read(2'b01, 2'b10, MY_ID, 2'b00, 10'h357, 1'b1, 2'b10, 10'h246, 0, 8);
    idle(10);

    chk("R9", "scoreboard drained", 68'(q.size()), 68'd0);
    finish_run();
  end
endmodule